// File: doc/BRIEF.md
# Modem Control Line Block

This block sits beside a serial port's data path and owns the modem-control wires. Two register bits set the data-terminal-ready and request-to-send pins; the pins are active low, so a 1 in the bit pulls the pin low. A loopback bit turns the serial data path back on itself inside the chip.

On the input side, four modem status lines (ring, clear-to-send, carrier detect and data-set-ready) pass through a two-flop synchronizer and can be read as levels. Clear-to-send and carrier detect also have edge capture. Each of the two lines has a mode bit. With the bit clear, only rising edges are recorded. With it set, both rising and falling edges are recorded. The recorded status is cleared when software reads the status register. Per-line mask bits combine the status into one pending signal. An enable bit then gates that signal into the interrupt request that goes to the port's main interrupt logic.

The register port is a simple strobe interface. Read data is combinational from the current state. A read of the status register clears the edge status on the next clock edge.

Top module: `modem_line_ctl`

## Requirements
- R1: After reset, both modem output pins are high, loopback is off, and all of the following are 0: edge status, masks, edge-mode bits, the source enable, `ext_pend_o` and `ext_irq_o`.
- R2: Control register (address 0): bit 0 drives `dtr_pin_o` and bit 1 drives `rts_pin_o`. Each pin is the inverse of its bit, one clock after the write.
- R3: Status register (address 1) bits 0..3 show the synchronized levels of cts, dcd, ri and dsr, in that order. An input change appears after two clock edges.
- R4: With a line's mode bit clear, a rising edge on that line sets its status bit (bit 4 for cts, bit 5 for dcd) three clock edges after the change. A falling edge sets nothing.
- R5: With a line's mode bit set (bit 10 for cts, bit 11 for dcd), both rising and falling edges set its status bit.
- R6: A read of address 1 returns the status as it was before the read, then clears both status bits.
- R7: An edge detected in the same cycle as a clearing read stays pending. Its status bit reads 1 afterwards.
- R8: `ext_pend_o` is the OR of each status bit ANDed with its mask bit (bit 8 for cts, bit 9 for dcd). `ext_irq_o` is `ext_pend_o` gated by the enable bit, which is bit 0 of address 2.
- R9: With control bit 2 set, `rx_data_o` follows `tx_data_i` and `ser_out_o` holds 1. With it clear, `rx_data_o` follows `ser_in_i` and `ser_out_o` follows `tx_data_i`.
- R10: One input transition sets status exactly once. An input level already present during reset produces no edge.
- R11: A write to address 1 changes only the mask and mode bits (bits 8..11) and leaves the edge status unchanged. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears edge status when the address is 1) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| ri_i | input | 1 | Ring indicator input, asynchronous |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dcd_i | input | 1 | Carrier detect input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| dtr_pin_o | output | 1 | Data-terminal-ready pin, inverse of control bit 0 |
| rts_pin_o | output | 1 | Request-to-send pin, inverse of control bit 1 |
| tx_data_i | input | 1 | Serial data from the transmitter |
| ser_in_i | input | 1 | Serial data from the receive pin |
| ser_out_o | output | 1 | Serial data to the transmit pin |
| rx_data_o | output | 1 | Serial data to the receiver |
| ext_pend_o | output | 1 | Combined masked edge status |
| ext_irq_o | output | 1 | Combined status gated by the source enable |

## Verification
The assertions check several relations on every cycle:
- each pin carries the inverse of the bit last written;
- a clearing read with no coincident edge empties the status;
- a detected edge always leaves its status bit set, even during a read;
- a status-register write never drops status;
- the interrupt request never rises without the pending signal.

Some behaviour only the bench scenarios can show: rising-only versus any-edge sensing, the three-edge latency from pin to status, silence for levels held through reset, and the loopback routing. Long constrained-random runs of toggling lines, reads and mode changes compare every read value and both interrupt outputs against a cycle model built from the requirements.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;
  localparam int N_LVL  = 4;  // cts, dcd, ri, dsr
  localparam int N_EDG  = 2;  // cts, dcd

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_IEN  = 2'd2;

  localparam int CTRL_DTR  = 0;
  localparam int CTRL_RTS  = 1;
  localparam int CTRL_LOOP = 2;

  localparam int STAT_LVL_LSB  = 0;
  localparam int STAT_EDG_LSB  = 4;
  localparam int STAT_MASK_LSB = 8;
  localparam int STAT_MODE_LSB = 10;

  typedef struct packed {
    logic loop;
    logic rts;
    logic dtr;
  } ctrl_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/modem_edge_cap.sv
module modem_edge_cap #(
  parameter int N       = 2,
  parameter int ARM_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] any_i,
  input  logic         clr_i,
  output logic [N-1:0] hit_o,
  output logic [N-1:0] stat_o
);
  localparam int CW = $clog2(ARM_CYC + 1);

  logic [CW-1:0] arm_q;
  logic          armed;
  logic [N-1:0]  prev_q;
  logic [N-1:0]  stat_q;

  assign armed = (arm_q == CW'(ARM_CYC));

  // hold off edge detection until the synchronizer holds real pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= '0;
    else if (!armed) arm_q <= arm_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign hit_o[g] = armed & (any_i[g] ? (lvl_i[g] ^ prev_q[g])
                                        : (lvl_i[g] & ~prev_q[g]));
    // new edge wins over a coincident clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[g] <= 1'b0;
      else         stat_q[g] <= (stat_q[g] & ~clr_i) | hit_o[g];
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/modem_regs.sv
module modem_regs
  import modem_line_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [N_LVL-1:0]  lvl_i,
  input  logic [N_EDG-1:0]  stat_i,
  output ctrl_t             ctrl_o,
  output logic [N_EDG-1:0]  mask_o,
  output logic [N_EDG-1:0]  mode_o,
  output logic              ien_o,
  output logic              clr_o,
  output logic [REG_DW-1:0] rdata_o
);
  ctrl_t             ctrl_q;
  logic [N_EDG-1:0]  mask_q;
  logic [N_EDG-1:0]  mode_q;
  logic              ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      mode_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_CTRL: begin
          ctrl_q.dtr  <= wdata_i[CTRL_DTR];
          ctrl_q.rts  <= wdata_i[CTRL_RTS];
          ctrl_q.loop <= wdata_i[CTRL_LOOP];
        end
        ADDR_STAT: begin
          mask_q <= wdata_i[STAT_MASK_LSB +: N_EDG];
          mode_q <= wdata_i[STAT_MODE_LSB +: N_EDG];
        end
        ADDR_IEN: ien_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_DTR]  = ctrl_q.dtr;
        rdata_o[CTRL_RTS]  = ctrl_q.rts;
        rdata_o[CTRL_LOOP] = ctrl_q.loop;
      end
      ADDR_STAT: begin
        rdata_o[STAT_LVL_LSB  +: N_LVL] = lvl_i;
        rdata_o[STAT_EDG_LSB  +: N_EDG] = stat_i;
        rdata_o[STAT_MASK_LSB +: N_EDG] = mask_q;
        rdata_o[STAT_MODE_LSB +: N_EDG] = mode_q;
      end
      ADDR_IEN: rdata_o[0] = ien_q;
      default: ;
    endcase
  end

  assign clr_o  = rd_i & (addr_i == ADDR_STAT);
  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign mode_o = mode_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              ri_i,
  input  logic              cts_i,
  input  logic              dcd_i,
  input  logic              dsr_i,
  output logic              dtr_pin_o,
  output logic              rts_pin_o,
  input  logic              tx_data_i,
  input  logic              ser_in_i,
  output logic              ser_out_o,
  output logic              rx_data_o,
  output logic              ext_pend_o,
  output logic              ext_irq_o
);
  localparam int ARM_CYC = SYNC_STAGES + 1;

  logic [N_LVL-1:0] raw_lvl, sync_lvl;
  logic [N_EDG-1:0] edge_hit, edge_stat, edge_mask, edge_mode;
  logic             stat_clr, src_en;
  ctrl_t            ctrl;

  assign raw_lvl = {dsr_i, ri_i, dcd_i, cts_i};

  modem_sync #(.W(N_LVL), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lvl),
    .q_o   (sync_lvl)
  );

  modem_edge_cap #(.N(N_EDG), .ARM_CYC(ARM_CYC)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl[N_EDG-1:0]),
    .any_i (edge_mode),
    .clr_i (stat_clr),
    .hit_o (edge_hit),
    .stat_o(edge_stat)
  );

  modem_regs i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .lvl_i  (sync_lvl),
    .stat_i (edge_stat),
    .ctrl_o (ctrl),
    .mask_o (edge_mask),
    .mode_o (edge_mode),
    .ien_o  (src_en),
    .clr_o  (stat_clr),
    .rdata_o(reg_rdata_o)
  );

  // pins are active low
  assign dtr_pin_o = ~ctrl.dtr;
  assign rts_pin_o = ~ctrl.rts;

  assign rx_data_o = ctrl.loop ? tx_data_i : ser_in_i;
  assign ser_out_o = ctrl.loop ? 1'b1      : tx_data_i;

  assign ext_pend_o = |(edge_stat & edge_mask);
  assign ext_irq_o  = ext_pend_o & src_en;
endmodule

// File: rtl/modem_line_chk.sv
module modem_line_chk
  import modem_line_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_DW-1:0] reg_wdata_i,
  input logic              dtr_pin_o,
  input logic              rts_pin_o,
  input logic              ext_pend_o,
  input logic              ext_irq_o,
  input logic [N_EDG-1:0]  stat_i,
  input logic [N_EDG-1:0]  hit_i
);
  // R2
  dtr_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_CTRL) |=> (dtr_pin_o == !$past(reg_wdata_i[CTRL_DTR])));
  // R2
  rts_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_CTRL) |=> (rts_pin_o == !$past(reg_wdata_i[CTRL_RTS])));
  // R6
  stat_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_STAT && hit_i == '0) |=> (stat_i == '0));
  // R7
  hit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((stat_i & $past(hit_i)) == $past(hit_i)));
  // R11
  wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_rd_i && reg_addr_i == ADDR_STAT)
      |=> ((stat_i & $past(stat_i)) == $past(stat_i)));
  // R8
  irq_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_o |-> ext_pend_o);
  // R8
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |-> !ext_pend_o);
endmodule

bind modem_line_ctl modem_line_chk i_modem_line_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .dtr_pin_o  (dtr_pin_o),
  .rts_pin_o  (rts_pin_o),
  .ext_pend_o (ext_pend_o),
  .ext_irq_o  (ext_irq_o),
  .stat_i     (edge_stat),
  .hit_i      (edge_hit)
);

// File: tb/test_modem_line_ctl.sv
module test_modem_line_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ri = 1'b0, cts = 1'b0, dcd = 1'b0, dsr = 1'b0;
  logic        dtr_pin, rts_pin;
  logic        tx_data = 1'b0, ser_in = 1'b0, ser_out, rx_data;
  logic        ext_pend, ext_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  modem_line_ctl i_modem_line_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ri_i(ri), .cts_i(cts), .dcd_i(dcd), .dsr_i(dsr),
    .dtr_pin_o(dtr_pin), .rts_pin_o(rts_pin),
    .tx_data_i(tx_data), .ser_in_i(ser_in), .ser_out_o(ser_out), .rx_data_o(rx_data),
    .ext_pend_o(ext_pend), .ext_irq_o(ext_irq)
  );

  // cycle model built from the requirements: levels after 2 edges, status after 3
  logic [3:0] m_s1, m_s2, m_prev;
  logic [1:0] m_stat, m_mask, m_mode, m_hit;
  logic       m_en;
  int         m_arm;

  function automatic logic [1:0] exp_hit(logic [1:0] now, logic [1:0] was,
                                         logic [1:0] mode, bit armed);
    logic [1:0] r;
    for (int i = 0; i < 2; i++)
      r[i] = armed && (mode[i] ? (now[i] != was[i]) : (now[i] && !was[i]));
    return r;
  endfunction

  function automatic logic [15:0] exp_stat_reg();
    return {4'b0, m_mode, m_mask, 2'b0, m_stat, m_s2};
  endfunction

  assign m_hit = exp_hit(m_s2[1:0], m_prev[1:0], m_mode, m_arm >= 3);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_arm <= 0;
      m_stat <= '0; m_mask <= '0; m_mode <= '0; m_en <= 1'b0;
    end else begin
      m_s1 <= {dsr, ri, dcd, cts};
      m_s2 <= m_s1;
      m_prev <= m_s2;
      if (m_arm < 3) m_arm <= m_arm + 1;
      m_stat <= (m_stat & ((reg_rd && reg_addr == 2'd1) ? 2'b00 : 2'b11)) | m_hit;
      if (reg_wr && reg_addr == 2'd1) {m_mode, m_mask} <= reg_wdata[11:8];
      if (reg_wr && reg_addr == 2'd2) m_en <= reg_wdata[0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_i);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk_i);
    reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  logic [15:0] rv;

  initial begin
    void'($urandom(32'h1f3a));
    cts = 1'b1;
    idle(3);
    rst_ni = 1'b1;
    idle(6);
    // R1 / R10: reset state, level present at reset gives no edge
    chk("R1 dtr pin", dtr_pin, 1);
    chk("R1 rts pin", rts_pin, 1);
    chk("R1 pend", ext_pend, 0);
    chk("R1 irq", ext_irq, 0);
    rd(2'd0, rv); chk("R1 ctrl reg", rv, 16'h0000);
    rd(2'd1, rv); chk("R10 no edge from reset level, R3 cts level", rv, 16'h0001);

    // R2
    wr(2'd0, 16'h0001);
    chk("R2 dtr low", dtr_pin, 0); chk("R2 rts high", rts_pin, 1);
    wr(2'd0, 16'h0002);
    chk("R2 dtr high", dtr_pin, 1); chk("R2 rts low", rts_pin, 0);

    // R9
    tx_data = 1'b0; ser_in = 1'b1; #1;
    chk("R9 rx from pin", rx_data, 1); chk("R9 out from tx", ser_out, 0);
    @(negedge clk_i);
    wr(2'd0, 16'h0004);
    chk("R9 loop rx", rx_data, 0); chk("R9 loop out idle", ser_out, 1);
    tx_data = 1'b1; #1;
    chk("R9 loop rx follows tx", rx_data, 1);
    @(negedge clk_i);
    wr(2'd0, 16'h0000);

    // R4: rising only, masks on
    wr(2'd1, 16'h0300);
    cts = 1'b0; idle(4);
    chk("R4 falling ignored pend", ext_pend, 0);
    rd(2'd1, rv); chk("R4 falling ignored", rv, 16'h0300);
    dcd = 1'b1; idle(2);
    rd(2'd1, rv); chk("R3 dcd level two edges", rv[3:0], 4'b0010);
    idle(2);
    chk("R8 pend from dcd", ext_pend, 1);
    chk("R8 irq gated off", ext_irq, 0);
    wr(2'd2, 16'h0001);
    chk("R8 irq enabled", ext_irq, 1);
    rd(2'd1, rv); chk("R4 rising dcd status", rv[5:4], 2'b10);
    rd(2'd1, rv); chk("R6 cleared by read", rv[5:4], 2'b00);
    chk("R6 pend cleared", ext_pend, 0);

    // R5: any-edge mode
    wr(2'd1, 16'h0F00);
    dcd = 1'b0; idle(4);
    cts = 1'b1; idle(4);
    // R11: write keeps status, address 3 reads zero
    wr(2'd1, 16'h0C00);
    chk("R11 masks off pend", ext_pend, 0);
    rd(2'd3, rv); chk("R11 addr3 zero", rv, 0);
    rd(2'd1, rv); chk("R5 both edges, R11 status kept", rv, 16'h0C31);

    // R7: edge coincident with clearing read
    wr(2'd1, 16'h0F00);
    cts = 1'b0;
    idle(2);
    rd(2'd1, rv); chk("R7 read returns old status", rv[5:4], 2'b00);
    chk("R7 edge kept pending", ext_pend, 1);
    rd(2'd1, rv); chk("R7 status bit set", rv[5:4], 2'b01);
    idle(10);
    rd(2'd1, rv); chk("R10 single transition single edge", rv[5:4], 2'b00);

    // constrained random against the model
    for (int it = 0; it < 6000; it++) begin
      int op;
      chk("R8 pend model", ext_pend, |(m_stat & m_mask));
      chk("R8 irq model", ext_irq, (|(m_stat & m_mask)) & m_en);
      if ($urandom_range(15) == 0) cts = ~cts;
      if ($urandom_range(15) == 0) dcd = ~dcd;
      if ($urandom_range(15) == 0) ri  = ~ri;
      if ($urandom_range(15) == 0) dsr = ~dsr;
      op = $urandom_range(31);
      if (op < 4) begin
        reg_rd = 1'b1; reg_addr = 2'd1; #1;
        chk("R3 R4 R5 R6 random read", reg_rdata, exp_stat_reg());
        @(negedge clk_i); reg_rd = 1'b0;
      end else if (op == 4) begin
        wr(2'd1, 16'($urandom_range(15)) << 8);
      end else if (op == 5) begin
        wr(2'd2, 16'($urandom_range(1)));
      end else begin
        @(negedge clk_i);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule